// File: doc/BRIEF.md
# Instruction Predecoder and Length Detector

This combinational block takes one 16-bit instruction word and sorts it into one of four formats by its leading bits: arithmetic, load/store, branch and miscellaneous. It pulls out the opcode and register fields of whichever format it finds. It reports whether a 16-bit immediate word follows the instruction, so fetch logic knows the instruction length. A skipped conditional uses the same answer to step over the next instruction.

For the arithmetic format, the block also resolves the 6-bit source selector. The result is either a register index or a ready-made 16-bit constant. The constant can be all ones, a power of two, a small unsigned literal, or the immediate word, which arrives on its own input. The block reads no registers, executes nothing and makes no memory access.

Top module: `instr_predecode`

## Requirements
- R1: `fmt` is 0 when bit 15 is 0 (arithmetic). It is 1 when bits 15:14 are 10 (load/store), 2 when bits 15:13 are 110 (branch), and 3 when bits 15:13 are 111 (misc).
- R2: In the arithmetic format, `opcode` is bits 14:10 and `reg_a` is bits 9:6. The source selector is bits 5:0.
- R3: In the load/store format, `opcode` is bits 13:12, `reg_a` is bits 11:8 and `mode` is bits 7:0.
- R4: In the branch format, `opcode` is bit 12 and `disp` is bits 11:0 sign-extended to 16 bits. `disp` is 0 in every other format.
- R5: In the misc format, `opcode` is bits 12:8, `reg_a` is bits 7:4 and `reg_y` is bits 3:0.
- R6: `has_imm` is 1 in exactly these cases: the arithmetic format with selector 0x10, the load/store format with mode in 0x10..0x2E, and the misc format with opcode 1. It is never 1 for the branch format.
- R7: A selector of 0x00..0x0F sets `src_is_reg` and puts the selector on `src_reg`, with `src_value` equal to 0.
- R8: Selector 0x10 passes `imm_word` to `src_value`. Selector 0x11 gives 0xFFFF.
- R9: Selector 0x15..0x1F gives 1 shifted left by (selector − 0x10), which covers 0x0020 through 0x8000.
- R10: Selector 0x20..0x3F gives (selector − 0x20), zero-extended, which covers 0..31.
- R11: Selector 0x12..0x14 raises `illegal_operand`. In that case `src_value` is 0 and `src_is_reg` is 0.
- R12: `illegal_opcode` is 1 only for the misc format with opcode 0x04..0x1F.
- R13: Outside the arithmetic format, `src_is_reg`, `src_value` and `illegal_operand` are all 0, whatever `imm_word` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 16 | Instruction word to decode |
| imm_word | input | 16 | Word following the instruction, used as the immediate |
| fmt | output | 2 | Format code (0 arith, 1 load/store, 2 branch, 3 misc) |
| opcode | output | 5 | Opcode, zero-extended |
| reg_a | output | 4 | Destination/first register field |
| reg_y | output | 4 | Second register field (misc format) |
| mode | output | 8 | Addressing mode field (load/store) |
| disp | output | 16 | Sign-extended branch displacement |
| src_is_reg | output | 1 | Source selector names a register |
| src_reg | output | 4 | Source register index |
| src_value | output | 16 | Resolved source constant |
| has_imm | output | 1 | A 16-bit immediate follows |
| illegal_operand | output | 1 | Source selector unassigned |
| illegal_opcode | output | 1 | Misc opcode reserved |

## Verification
The bench probes each edge of the load/store immediate window: 0x0F, 0x10, 0x2E and 0x2F. A decoder with an off-by-one bound would report the wrong length there and misalign fetch after that instruction.

It walks every power-of-two and literal selector. A wrong shift base or sign extension would then show up as a wrong constant. Branch displacements at 0x7FF and 0x800 expose a missing or misplaced sign bit. The unassigned selectors and reserved misc opcodes are checked for a clean zero value. The bench also checks that a non-arithmetic word lets no immediate leak into the source value.

// File: rtl/instr_predecode.sv
module instr_predecode (
  input  logic [15:0] instr_word,
  input  logic [15:0] imm_word,
  output logic [1:0]  fmt,
  output logic [4:0]  opcode,
  output logic [3:0]  reg_a,
  output logic [3:0]  reg_y,
  output logic [7:0]  mode,
  output logic [15:0] disp,
  output logic        src_is_reg,
  output logic [3:0]  src_reg,
  output logic [15:0] src_value,
  output logic        has_imm,
  output logic        illegal_operand,
  output logic        illegal_opcode
);

  localparam logic [1:0] FMT_ARITH = 2'd0;
  localparam logic [1:0] FMT_LDST  = 2'd1;
  localparam logic [1:0] FMT_BR    = 2'd2;
  localparam logic [1:0] FMT_MISC  = 2'd3;

  logic [5:0] sel;
  logic       is_arith;

  assign fmt = !instr_word[15] ? FMT_ARITH :
               !instr_word[14] ? FMT_LDST  :
               !instr_word[13] ? FMT_BR    : FMT_MISC;

  assign is_arith = (fmt == FMT_ARITH);
  assign sel      = instr_word[5:0];

  always_comb begin
    opcode  = '0;
    reg_a   = '0;
    reg_y   = '0;
    mode    = '0;
    disp    = '0;
    has_imm = 1'b0;
    illegal_opcode = 1'b0;
    case (fmt)
      FMT_ARITH: begin
        opcode  = instr_word[14:10];
        reg_a   = instr_word[9:6];
        has_imm = (sel == 6'h10);
      end
      FMT_LDST: begin
        opcode  = {3'b000, instr_word[13:12]};
        reg_a   = instr_word[11:8];
        mode    = instr_word[7:0];
        has_imm = (instr_word[7:0] >= 8'h10) && (instr_word[7:0] <= 8'h2E);
      end
      FMT_BR: begin
        opcode  = {4'b0000, instr_word[12]};
        disp    = {{4{instr_word[11]}}, instr_word[11:0]};
      end
      default: begin
        opcode  = instr_word[12:8];
        reg_a   = instr_word[7:4];
        reg_y   = instr_word[3:0];
        has_imm = (instr_word[12:8] == 5'd1);
        illegal_opcode = (instr_word[12:8] >= 5'd4);
      end
    endcase
  end

  always_comb begin
    src_is_reg      = 1'b0;
    src_reg         = '0;
    src_value       = '0;
    illegal_operand = 1'b0;
    if (is_arith) begin
      if (!sel[5] && !sel[4]) begin
        src_is_reg = 1'b1;
        src_reg    = sel[3:0];
      end else if (sel[5]) begin
        src_value  = {11'd0, sel[4:0]};
      end else begin
        case (sel[3:0])
          4'h0:                src_value = imm_word;
          4'h1:                src_value = 16'hFFFF;
          4'h2, 4'h3, 4'h4:    illegal_operand = 1'b1;
          default:             src_value = 16'd1 << sel[3:0];
        endcase
      end
    end
  end

  always_comb begin
    AST_BRANCH_NO_IMM: assert (!(fmt == FMT_BR && has_imm)); // R6
    AST_REG_NO_CONST: assert (!(src_is_reg && src_value != 16'd0)); // R7
    AST_ILLEGAL_OPERAND_QUIET: assert (!(illegal_operand && (src_is_reg || src_value != 16'd0 || has_imm))); // R11
    AST_ILLEGAL_OPCODE_MISC: assert (!(illegal_opcode && (fmt != FMT_MISC || has_imm))); // R12
    AST_NONARITH_SRC_QUIET: assert (is_arith || (!src_is_reg && src_value == 16'd0 && !illegal_operand)); // R13
    AST_DISP_ONLY_BRANCH: assert (fmt == FMT_BR || disp == 16'd0); // R4
  end

endmodule

// File: tb/tb_instr_predecode.sv
module tb_instr_predecode;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] instr_word, imm_word;
  logic [1:0]  fmt;
  logic [4:0]  opcode;
  logic [3:0]  reg_a, reg_y, src_reg;
  logic [7:0]  mode;
  logic [15:0] disp, src_value;
  logic        src_is_reg, has_imm, illegal_operand, illegal_opcode;

  instr_predecode dut (
    .instr_word(instr_word), .imm_word(imm_word), .fmt(fmt), .opcode(opcode),
    .reg_a(reg_a), .reg_y(reg_y), .mode(mode), .disp(disp),
    .src_is_reg(src_is_reg), .src_reg(src_reg), .src_value(src_value),
    .has_imm(has_imm), .illegal_operand(illegal_operand), .illegal_opcode(illegal_opcode)
  );

  typedef struct packed {
    logic [15:0] w;
    logic [15:0] imm;
    logic [1:0]  f;
    logic [4:0]  op;
    logic        hi;
    logic        ir;
    logic [15:0] v;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{16'h00C5, 16'h1111, 2'd0, 5'h00, 1'b0, 1'b1, 16'h0000},
    '{16'h2450, 16'hBEEF, 2'd0, 5'h09, 1'b1, 1'b0, 16'hBEEF},
    '{16'h3491, 16'h1234, 2'd0, 5'h0D, 1'b0, 1'b0, 16'hFFFF},
    '{16'h0015, 16'h0000, 2'd0, 5'h00, 1'b0, 1'b0, 16'h0020},
    '{16'h001F, 16'h0000, 2'd0, 5'h00, 1'b0, 1'b0, 16'h8000},
    '{16'h0020, 16'h5555, 2'd0, 5'h00, 1'b0, 1'b0, 16'h0000},
    '{16'h003F, 16'h5555, 2'd0, 5'h00, 1'b0, 1'b0, 16'h001F},
    '{16'h000F, 16'h5555, 2'd0, 5'h00, 1'b0, 1'b1, 16'h0000},
    '{16'h7C00, 16'h0000, 2'd0, 5'h1F, 1'b0, 1'b1, 16'h0000},
    '{16'h800F, 16'hAAAA, 2'd1, 5'h00, 1'b0, 1'b0, 16'h0000},
    '{16'h8010, 16'hAAAA, 2'd1, 5'h00, 1'b1, 1'b0, 16'h0000},
    '{16'h802E, 16'hAAAA, 2'd1, 5'h00, 1'b1, 1'b0, 16'h0000},
    '{16'h802F, 16'hAAAA, 2'd1, 5'h00, 1'b0, 1'b0, 16'h0000},
    '{16'hB0FF, 16'hAAAA, 2'd1, 5'h03, 1'b0, 1'b0, 16'h0000},
    '{16'hC000, 16'hAAAA, 2'd2, 5'h00, 1'b0, 1'b0, 16'h0000},
    '{16'hD000, 16'hAAAA, 2'd2, 5'h01, 1'b0, 1'b0, 16'h0000},
    '{16'hC010, 16'hAAAA, 2'd2, 5'h00, 1'b0, 1'b0, 16'h0000},
    '{16'hE000, 16'hAAAA, 2'd3, 5'h00, 1'b0, 1'b0, 16'h0000},
    '{16'hE100, 16'h1234, 2'd3, 5'h01, 1'b1, 1'b0, 16'h0000},
    '{16'hE200, 16'hAAAA, 2'd3, 5'h02, 1'b0, 1'b0, 16'h0000},
    '{16'hFF00, 16'hAAAA, 2'd3, 5'h1F, 1'b0, 1'b0, 16'h0000},
    '{16'h6010, 16'h0001, 2'd0, 5'h18, 1'b1, 1'b0, 16'h0001},
    '{16'hE110, 16'h7777, 2'd3, 5'h01, 1'b1, 1'b0, 16'h0000}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s word=%h actual=%h expected=%h", req, instr_word, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [15:0] i);
    @(negedge clk);
    instr_word = w;
    imm_word   = i;
    #1;
  endtask

  initial begin
    instr_word = 16'h0000;
    imm_word   = 16'h0000;
    repeat (2) @(posedge clk);
    apply(16'h0000, 16'h0000);
    chk("R1 reset word fmt", {30'd0, fmt}, 32'd0);
    chk("R7 reset word is_reg", {31'd0, src_is_reg}, 32'd1);
    chk("R6 reset word has_imm", {31'd0, has_imm}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].w, VECS[k].imm);
      chk("R1 fmt", {30'd0, fmt}, {30'd0, VECS[k].f});
      chk("R2 opcode", {27'd0, opcode}, {27'd0, VECS[k].op});
      chk("R6 has_imm", {31'd0, has_imm}, {31'd0, VECS[k].hi});
      chk("R7 src_is_reg", {31'd0, src_is_reg}, {31'd0, VECS[k].ir});
      chk("R13 src_value", {16'd0, src_value}, {16'd0, VECS[k].v});
    end

    apply(16'h00C5, 16'h0);
    chk("R7 src_reg", {28'd0, src_reg}, 32'd5);
    chk("R2 reg_a", {28'd0, reg_a}, 32'd3);
    apply(16'h2450, 16'hBEEF);
    chk("R2 reg_a imm form", {28'd0, reg_a}, 32'd1);
    chk("R8 imm passthrough", {16'd0, src_value}, 32'hBEEF);

    apply(16'h9A5C, 16'h0);
    chk("R3 opcode", {27'd0, opcode}, 32'd1);
    chk("R3 reg_a", {28'd0, reg_a}, 32'hA);
    chk("R3 mode", {24'd0, mode}, 32'h5C);

    apply(16'hC7FF, 16'h0);
    chk("R4 disp positive max", {16'd0, disp}, 32'h07FF);
    apply(16'hC800, 16'h0);
    chk("R4 disp negative min", {16'd0, disp}, 32'hF800);
    apply(16'hDFFF, 16'h0);
    chk("R4 disp minus one", {16'd0, disp}, 32'hFFFF);
    chk("R4 branch opcode", {27'd0, opcode}, 32'd1);
    apply(16'h0FFF, 16'h0);
    chk("R4 disp zero outside branch", {16'd0, disp}, 32'd0);

    apply(16'hE1AB, 16'h0);
    chk("R5 reg_a x field", {28'd0, reg_a}, 32'hA);
    chk("R5 reg_y", {28'd0, reg_y}, 32'hB);
    chk("R5 opcode", {27'd0, opcode}, 32'd1);

    for (int b = 6'h15; b <= 6'h1F; b++) begin
      apply({10'd0, b[5:0]}, 16'hFFFF);
      chk("R9 power of two", {16'd0, src_value}, 32'd1 << (b - 16));
      chk("R9 not reg", {31'd0, src_is_reg}, 32'd0);
    end
    for (int b = 6'h20; b <= 6'h3F; b++) begin
      apply({10'd0, b[5:0]}, 16'hFFFF);
      chk("R10 literal", {16'd0, src_value}, b - 32);
    end
    for (int b = 6'h12; b <= 6'h14; b++) begin
      apply({10'd0, b[5:0]}, 16'hFFFF);
      chk("R11 illegal_operand", {31'd0, illegal_operand}, 32'd1);
      chk("R11 value zero", {16'd0, src_value}, 32'd0);
      chk("R11 not reg", {31'd0, src_is_reg}, 32'd0);
    end
    apply(16'h0011, 16'h0);
    chk("R11 0x11 legal", {31'd0, illegal_operand}, 32'd0);
    chk("R8 all ones", {16'd0, src_value}, 32'hFFFF);

    apply(16'hE300, 16'h0);
    chk("R12 misc op3 legal", {31'd0, illegal_opcode}, 32'd0);
    apply(16'hE400, 16'h0);
    chk("R12 misc op4 reserved", {31'd0, illegal_opcode}, 32'd1);
    apply(16'hFF00, 16'h0);
    chk("R12 misc op1F reserved", {31'd0, illegal_opcode}, 32'd1);
    apply(16'h7C00, 16'h0);
    chk("R12 arith not flagged", {31'd0, illegal_opcode}, 32'd0);

    apply(16'h8012, 16'hFFFF);
    chk("R13 ldst no illegal_operand", {31'd0, illegal_operand}, 32'd0);
    chk("R13 ldst src_value", {16'd0, src_value}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule